// File: doc/BRIEF.md
# Basic-Rate Channel Group Timeslot Multiplexer

The block builds and splits a 2.048 Mbit/s serial frame of 32 eight-bit timeslots that carries several basic-rate ISDN channel groups. A group holds two 8-bit bearer channels and one 2-bit signalling channel. Group n always sits in three neighbouring timeslots: first bearer in slot 3n, second bearer in slot 3n+1, signalling in slot 3n+2. Only the top two bits of the signalling slot carry data; its lower six bits are padding.

The clock input is the bit clock and a frame sync input marks the frame start. Both come from outside. On transmit, parallel per-group bytes are captured at the frame start and shifted out MSB first. On receive, the serial line is deserialised. Each enabled group's three values are handed out together with a one-cycle strobe. A group-count input selects how many groups, from slot 0 upward, are live.

Top module: `bri_tdm_mux`

## Requirements
- R1: After a clock edge with `fsc_i` high, the next cycle carries frame bit 0 (timeslot 0, its MSB). Each timeslot spans 8 cycles, MSB first, and a frame spans 32 timeslots. Before the first sync, `tx_o` is 1.
- R2: Group g sends its first bearer byte `tx_b1_i[8g+:8]` in slot 3g and its second bearer byte `tx_b2_i[8g+:8]` in slot 3g+1.
- R3: Slot 3g+2 carries `tx_d_i[2g+1]` as its first bit and `tx_d_i[2g]` as its second bit. Its remaining six bits go out as 1.
- R4: Every timeslot at or above 3 × (effective group count) goes out as all ones.
- R5: `grp_cnt_i` is sampled only at a sync edge. A value of 0 acts as 1, and values above 10 act as 10.
- R6: After the last bit of slot 3g+2 of an enabled group g is sampled, the next cycle shows the following together: `rx_vld_o[g]` high for exactly one cycle, and `rx_b1_o`/`rx_b2_o` for group g updated to that frame's slot 3g and slot 3g+1 bytes.
- R7: `rx_d_o[2g+:2]` takes the first two received bits of slot 3g+2, first bit in the upper position. The six masked bits have no effect on any output.
- R8: Received slots of disabled groups, and slots 30 and 31, produce no strobe and leave every receive output unchanged.
- R9: While reset is low and after it, until new data is strobed, `tx_o` is 1, `rx_vld_o` is 0 and every receive output is 0.
- R10: Transmit bytes are captured at the sync edge. Changing them mid-frame does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock (2.048 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsc_i | input | 1 | Frame sync, one cycle high before bit 0 |
| grp_cnt_i | input | 4 | Number of live groups, 1 to 10 |
| tx_b1_i | input | 80 | First bearer byte per group, group g at [8g+:8] |
| tx_b2_i | input | 80 | Second bearer byte per group |
| tx_d_i | input | 20 | Signalling bits per group, group g at [2g+:2] |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rx_b1_o | output | 80 | Received first bearer byte per group |
| rx_b2_o | output | 80 | Received second bearer byte per group |
| rx_d_o | output | 20 | Received signalling bits per group |
| rx_vld_o | output | 10 | One-cycle strobe per group |

## Verification
The hardest case to reach is a group-count or data change that arrives in the middle of a frame. It must not move the slot boundaries or alter the bits already committed for that frame. The stimulus rewrites every transmit byte and the group count at bit 100 of selected frames. The checks still expect the values captured at the sync edge. Directed frames use counts 0, 10 and 15 to hit both clamp limits. Random receive bytes fill the masked signalling bits and the unused slots, so any leakage shows up in the held outputs checked at the end of each frame.

// File: rtl/bri_tdm_pkg.sv
package bri_tdm_pkg;
  typedef enum logic [1:0] {
    SLOT_B1 = 2'd0,
    SLOT_B2 = 2'd1,
    SLOT_D  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/bri_frame_timer.sv
module bri_frame_timer
  import bri_tdm_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int MAX_GRP   = 10,
  parameter int GRP_W     = 4,
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int TS_W     = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsc_i,
  input  logic [GRP_W-1:0] grp_cnt_i,
  output logic             active_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output slot_kind_e       kind_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             in_use_o,
  output logic             slot_last_o
);
  logic [TS_W-1:0]  ts_q;
  logic [BIT_W-1:0] bit_q;
  slot_kind_e       kind_q;
  logic [GRP_W-1:0] grp_q, cnt_q, cnt_d;
  logic             act_q;

  always_comb begin
    if (grp_cnt_i == '0)                       cnt_d = GRP_W'(1);
    else if (grp_cnt_i > GRP_W'(MAX_GRP))      cnt_d = GRP_W'(MAX_GRP);
    else                                       cnt_d = grp_cnt_i;
  end

  assign slot_last_o = act_q && (bit_q == BIT_W'(SLOT_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q   <= '0;
      bit_q  <= '0;
      kind_q <= SLOT_B1;
      grp_q  <= '0;
      cnt_q  <= GRP_W'(1);
      act_q  <= 1'b0;
    end else if (fsc_i) begin
      ts_q   <= '0;
      bit_q  <= '0;
      kind_q <= SLOT_B1;
      grp_q  <= '0;
      cnt_q  <= cnt_d;
      act_q  <= 1'b1;
    end else if (act_q) begin
      bit_q <= bit_q + 1'b1;
      if (slot_last_o) begin
        bit_q <= '0;
        if (ts_q == TS_W'(SLOTS - 1)) begin
          ts_q   <= '0;
          kind_q <= SLOT_B1;
          grp_q  <= '0;
        end else begin
          ts_q <= ts_q + 1'b1;
          case (kind_q)
            SLOT_B1: kind_q <= SLOT_B2;
            SLOT_B2: kind_q <= SLOT_D;
            default: begin
              kind_q <= SLOT_B1;
              grp_q  <= grp_q + 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign active_o  = act_q;
  assign bit_idx_o = bit_q;
  assign kind_o    = kind_q;
  assign grp_o     = grp_q;
  assign in_use_o  = act_q && (grp_q < cnt_q);

  a_r1_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsc_i |=> (bit_q == '0 && ts_q == '0 && kind_q == SLOT_B1 && act_q));
  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= GRP_W'(1)) && (cnt_q <= GRP_W'(MAX_GRP)));
  a_r5_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsc_i |=> $stable(cnt_q));
endmodule

// File: rtl/bri_tx_ser.sv
module bri_tx_ser
  import bri_tdm_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int D_BITS    = 2,
  parameter int MAX_GRP   = 10,
  parameter int GRP_W     = 4,
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fsc_i,
  input  logic [MAX_GRP*SLOT_BITS-1:0] b1_i,
  input  logic [MAX_GRP*SLOT_BITS-1:0] b2_i,
  input  logic [MAX_GRP*D_BITS-1:0]    d_i,
  input  logic                         active_i,
  input  logic [BIT_W-1:0]             bit_idx_i,
  input  slot_kind_e                   kind_i,
  input  logic [GRP_W-1:0]             grp_i,
  input  logic                         in_use_i,
  output logic                         tx_o
);
  logic [SLOT_BITS-1:0] b1_q [MAX_GRP];
  logic [SLOT_BITS-1:0] b2_q [MAX_GRP];
  logic [D_BITS-1:0]    d_q  [MAX_GRP];
  logic [SLOT_BITS-1:0] word;
  logic [GRP_W-1:0]     gidx;

  // frame-stable copy of the parallel inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < MAX_GRP; g++) begin
        b1_q[g] <= '1;
        b2_q[g] <= '1;
        d_q[g]  <= '1;
      end
    end else if (fsc_i) begin
      for (int g = 0; g < MAX_GRP; g++) begin
        b1_q[g] <= b1_i[g*SLOT_BITS +: SLOT_BITS];
        b2_q[g] <= b2_i[g*SLOT_BITS +: SLOT_BITS];
        d_q[g]  <= d_i[g*D_BITS +: D_BITS];
      end
    end
  end

  assign gidx = in_use_i ? grp_i : '0;

  always_comb begin
    word = '1;
    if (in_use_i) begin
      case (kind_i)
        SLOT_B1: word = b1_q[gidx];
        SLOT_B2: word = b2_q[gidx];
        default: word = {d_q[gidx], {(SLOT_BITS-D_BITS){1'b1}}};
      endcase
    end
  end

  assign tx_o = active_i ? word[BIT_W'(SLOT_BITS-1) - bit_idx_i] : 1'b1;

  a_r4_idle_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_use_i |-> tx_o);
  a_r3_mask_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_use_i && kind_i == SLOT_D && bit_idx_i >= BIT_W'(D_BITS)) |-> tx_o);
endmodule

// File: rtl/bri_rx_deser.sv
module bri_rx_deser
  import bri_tdm_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int D_BITS    = 2,
  parameter int MAX_GRP   = 10,
  parameter int GRP_W     = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rx_i,
  input  logic                         active_i,
  input  slot_kind_e                   kind_i,
  input  logic [GRP_W-1:0]             grp_i,
  input  logic                         in_use_i,
  input  logic                         slot_last_i,
  output logic [MAX_GRP*SLOT_BITS-1:0] b1_o,
  output logic [MAX_GRP*SLOT_BITS-1:0] b2_o,
  output logic [MAX_GRP*D_BITS-1:0]    d_o,
  output logic [MAX_GRP-1:0]           vld_o
);
  logic [SLOT_BITS-2:0] sr_q;
  logic [SLOT_BITS-1:0] byte_w, b1_hold, b2_hold;
  logic [SLOT_BITS-1:0] b1_q [MAX_GRP];
  logic [SLOT_BITS-1:0] b2_q [MAX_GRP];
  logic [D_BITS-1:0]    d_q  [MAX_GRP];
  logic [MAX_GRP-1:0]   vld_q;

  assign byte_w = {sr_q, rx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      b1_hold <= '0;
      b2_hold <= '0;
      vld_q   <= '0;
      for (int g = 0; g < MAX_GRP; g++) begin
        b1_q[g] <= '0;
        b2_q[g] <= '0;
        d_q[g]  <= '0;
      end
    end else begin
      vld_q <= '0;
      if (active_i) sr_q <= byte_w[SLOT_BITS-2:0];
      if (slot_last_i && in_use_i) begin
        case (kind_i)
          SLOT_B1: b1_hold <= byte_w;
          SLOT_B2: b2_hold <= byte_w;
          default: begin
            b1_q[grp_i]  <= b1_hold;
            b2_q[grp_i]  <= b2_hold;
            d_q[grp_i]   <= byte_w[SLOT_BITS-1 -: D_BITS];
            vld_q[grp_i] <= 1'b1;
          end
        endcase
      end
    end
  end

  for (genvar g = 0; g < MAX_GRP; g++) begin : g_out
    assign b1_o[g*SLOT_BITS +: SLOT_BITS] = b1_q[g];
    assign b2_o[g*SLOT_BITS +: SLOT_BITS] = b2_q[g];
    assign d_o[g*D_BITS +: D_BITS]        = d_q[g];
  end
  assign vld_o = vld_q;

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vld_q));
  a_r6_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vld_q) |=> !(|vld_q));
  a_r8_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vld_q) |-> $past(slot_last_i && in_use_i && kind_i == SLOT_D));
  a_r8_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|vld_q) |-> ($stable(b1_o) && $stable(b2_o) && $stable(d_o)));
endmodule

// File: rtl/bri_tdm_mux.sv
module bri_tdm_mux
  import bri_tdm_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int D_BITS    = 2,
  parameter int MAX_GRP   = 10,
  localparam int GRP_W    = $clog2(MAX_GRP + 1),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fsc_i,
  input  logic [GRP_W-1:0]             grp_cnt_i,
  input  logic [MAX_GRP*SLOT_BITS-1:0] tx_b1_i,
  input  logic [MAX_GRP*SLOT_BITS-1:0] tx_b2_i,
  input  logic [MAX_GRP*D_BITS-1:0]    tx_d_i,
  output logic                         tx_o,
  input  logic                         rx_i,
  output logic [MAX_GRP*SLOT_BITS-1:0] rx_b1_o,
  output logic [MAX_GRP*SLOT_BITS-1:0] rx_b2_o,
  output logic [MAX_GRP*D_BITS-1:0]    rx_d_o,
  output logic [MAX_GRP-1:0]           rx_vld_o
);
  logic             active, in_use, slot_last;
  logic [BIT_W-1:0] bit_idx;
  slot_kind_e       kind;
  logic [GRP_W-1:0] grp;

  bri_frame_timer #(
    .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .MAX_GRP(MAX_GRP), .GRP_W(GRP_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsc_i(fsc_i), .grp_cnt_i(grp_cnt_i),
    .active_o(active), .bit_idx_o(bit_idx), .kind_o(kind), .grp_o(grp),
    .in_use_o(in_use), .slot_last_o(slot_last)
  );

  bri_tx_ser #(
    .SLOT_BITS(SLOT_BITS), .D_BITS(D_BITS), .MAX_GRP(MAX_GRP), .GRP_W(GRP_W)
  ) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsc_i(fsc_i),
    .b1_i(tx_b1_i), .b2_i(tx_b2_i), .d_i(tx_d_i),
    .active_i(active), .bit_idx_i(bit_idx), .kind_i(kind), .grp_i(grp),
    .in_use_i(in_use), .tx_o(tx_o)
  );

  bri_rx_deser #(
    .SLOT_BITS(SLOT_BITS), .D_BITS(D_BITS), .MAX_GRP(MAX_GRP), .GRP_W(GRP_W)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .active_i(active),
    .kind_i(kind), .grp_i(grp), .in_use_i(in_use), .slot_last_i(slot_last),
    .b1_o(rx_b1_o), .b2_o(rx_b2_o), .d_o(rx_d_o), .vld_o(rx_vld_o)
  );
endmodule

// File: tb/tb_bri_tdm_mux.sv
module tb_bri_tdm_mux;
  localparam int G = 10;

  logic clk = 1'b0, rst_n = 1'b0, fsc = 1'b0, rx = 1'b1;
  logic [3:0] grp_cnt = 4'd1;
  logic [G*8-1:0] tb1 = '0, tb2 = '0;
  logic [G*2-1:0] td = '0;
  logic tx;
  logic [G*8-1:0] rb1, rb2;
  logic [G*2-1:0] rd;
  logic [G-1:0] vld;

  int n_run = 0, n_fail = 0;
  logic [G*8-1:0] fb1, fb2, m_b1, m_b2;
  logic [G*2-1:0] fd, m_d;
  int fcnt;
  logic [7:0] rxb [32];

  bri_tdm_mux dut (
    .clk_i(clk), .rst_ni(rst_n), .fsc_i(fsc), .grp_cnt_i(grp_cnt),
    .tx_b1_i(tb1), .tx_b2_i(tb2), .tx_d_i(td), .tx_o(tx), .rx_i(rx),
    .rx_b1_o(rb1), .rx_b2_o(rb2), .rx_d_o(rd), .rx_vld_o(vld)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp(input int c);
    if (c == 0) return 1;
    if (c > G) return G;
    return c;
  endfunction

  function automatic bit tx_exp(input int k);
    int ts = k / 8, b = k % 8, g, s;
    logic [7:0] w;
    if (ts >= 3 * fcnt) return 1'b1;
    g = ts / 3; s = ts % 3;
    if (s == 0)      w = fb1[g*8 +: 8];
    else if (s == 1) w = fb2[g*8 +: 8];
    else             w = {fd[g*2 +: 2], 6'h3f};
    return w[7-b];
  endfunction

  function automatic string tx_tag(input int k, input bit mid);
    int ts = k / 8;
    if (k < 8) return "R1";
    if (ts >= 3 * fcnt) return "R4";
    if (mid && k > 100) return "R10";
    if (ts % 3 == 2) return "R3";
    return "R2";
  endfunction

  task automatic run_frame(input int cnt_in, input bit mid);
    @(negedge clk);
    fsc = 1'b1;
    grp_cnt = 4'(cnt_in);
    for (int i = 0; i < G; i++) begin
      tb1[i*8 +: 8] = 8'($urandom);
      tb2[i*8 +: 8] = 8'($urandom);
      td[i*2 +: 2]  = 2'($urandom);
    end
    for (int i = 0; i < 32; i++) rxb[i] = 8'($urandom);
    fb1 = tb1; fb2 = tb2; fd = td; fcnt = clamp(cnt_in);
    for (int k = 0; k < 256; k++) begin
      logic [G-1:0] ev;
      int p, g;
      @(negedge clk);
      fsc = 1'b0;
      rx = rxb[k/8][7 - k%8];
      if (mid && k == 100) begin
        tb1 = ~tb1; tb2 = ~tb2; td = ~td;
        grp_cnt = 4'($urandom);
      end
      chk(tx == tx_exp(k), tx_tag(k, mid), $sformatf("tx bit %0d", k),
          tx, tx_exp(k));
      ev = '0; p = k - 1; g = p / 24;
      if (k >= 1 && p % 8 == 7 && (p / 8) % 3 == 2 && g < fcnt) begin
        ev[g] = 1'b1;
        m_b1[g*8 +: 8] = rxb[3*g];
        m_b2[g*8 +: 8] = rxb[3*g+1];
        m_d[g*2 +: 2]  = rxb[3*g+2][7:6];
      end
      chk(vld == ev, (p / 8 >= 3 * fcnt) ? "R8" : "R6",
          $sformatf("strobe after bit %0d", k), vld, ev);
      if (ev != '0) begin
        chk(rb1[g*8 +: 8] == m_b1[g*8 +: 8], "R6", "rx b1", rb1[g*8 +: 8], m_b1[g*8 +: 8]);
        chk(rb2[g*8 +: 8] == m_b2[g*8 +: 8], "R6", "rx b2", rb2[g*8 +: 8], m_b2[g*8 +: 8]);
        chk(rd[g*2 +: 2] == m_d[g*2 +: 2], "R7", "rx d", rd[g*2 +: 2], m_d[g*2 +: 2]);
      end
    end
    chk(rb1 == m_b1, "R8", "held b1", rb1, m_b1);
    chk(rb2 == m_b2, "R8", "held b2", rb2, m_b2);
    chk(rd == m_d, "R8", "held d", rd, m_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b21));
    m_b1 = '0; m_b2 = '0; m_d = '0;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R9", "tx in reset", tx, 1);
    chk(vld == '0, "R9", "strobe in reset", vld, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx == 1'b1, "R1", "tx before first sync", tx, 1);
    chk(rb1 == '0 && rb2 == '0 && rd == '0, "R9", "rx outputs after reset",
        rb1 ^ rb2, 0);
    run_frame(0, 1'b0);   // R5 low clamp
    run_frame(10, 1'b0);
    run_frame(15, 1'b1);  // R5 high clamp, R10 mid change
    run_frame(3, 1'b1);
    run_frame(1, 1'b0);
    for (int f = 0; f < 8; f++) run_frame(int'($urandom_range(0, 15)), f[0]);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule